// File: doc/BRIEF.md
# Floating-Point Multi-Register Transfer Cracker

This block turns one floating-point load/store-multiple instruction into a stream of micro-ops for a downstream issue stage. An instruction is taken on a valid/ready handshake while the block is idle. The block then emits three transfer micro-ops for each register moved and, when the instruction asks for base update, one more micro-op that carries an encoded add/subtract of the scaled displacement into the base register. The final micro-op of every instruction carries a last flag.

The register count comes from two scattered instruction bits, and the encoding zero stands for four registers. The displacement is the 8-bit immediate scaled to a byte offset. It sets the start offset of a pre-indexed transfer and is also the amount the base-update micro-op applies. Micro-ops leave on their own valid/ready handshake. A stalled micro-op holds steady until it is taken. A one-cycle done pulse follows acceptance of the final micro-op, and in that cycle the block is idle again.

Top module: `fpmx_cracker`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, uop_valid_o and done_o are 0 and inst_ready_o is 1.
- R2: The register count is {inst bit 22, inst bit 15}, with encoding 0 meaning 4. The block emits exactly 3 x count transfer micro-ops (uop_wb_o = 0).
- R3: Transfer micro-ops come in groups of three whose uop_slot_o tags are 0, 1, 2 in that order. All three carry the same uop_reg_o. For group g this is (inst bits 14:12 + g) modulo 8.
- R4: The displacement is inst bits 7:0 shifted left by two. Each transfer micro-op has uop_offset_o equal to the displacement when inst bit 24 is 1 and 0 when it is 0. Every micro-op carries uop_load_o = inst bit 20 and uop_up_o = inst bit 23.
- R5: Exactly one base-update micro-op (uop_wb_o = 1) follows the transfers when inst bit 21 is 1, and none is emitted when it is 0. Its uop_offset_o is the displacement, and uop_up_o selects add (1) or subtract (0).
- R6: The base-update micro-op's uop_word_o equals (inst bits 31:28 placed at 31:28) OR 0x02400000 OR (Rn << 16) OR (Rn << 12) OR displacement, where Rn is inst bits 19:16. uop_word_o is 0 on transfer micro-ops.
- R7: uop_last_o is 1 on the final micro-op of an instruction and 0 on every other one.
- R8: While uop_valid_o is 1 and uop_ready_i is 0, every micro-op output holds its value into the next cycle.
- R9: inst_ready_o is 0 from acceptance until the final micro-op is accepted. An instruction offered in that time is not taken and does not change the stream.
- R10: done_o is 1 for exactly the one cycle after the final micro-op is accepted. In that cycle uop_valid_o is 0 and inst_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inst_valid_i | input | 1 | Instruction offered |
| inst_ready_o | output | 1 | Block idle, instruction taken this cycle if offered |
| inst_i | input | 32 | Instruction word |
| uop_valid_o | output | 1 | Micro-op presented |
| uop_ready_i | input | 1 | Consumer takes the micro-op |
| uop_wb_o | output | 1 | 1 for base-update micro-op, 0 for transfer |
| uop_slot_o | output | 2 | Position within the three-micro-op group |
| uop_reg_o | output | 3 | Register index of the transfer |
| uop_offset_o | output | 10 | Start offset (transfer) or base adjustment (update) |
| uop_load_o | output | 1 | Load direction |
| uop_up_o | output | 1 | Add (1) or subtract (0) direction |
| uop_word_o | output | 32 | Encoded base-update operation, 0 on transfers |
| uop_last_o | output | 1 | Final micro-op of the instruction |
| done_o | output | 1 | One-cycle pulse after the final micro-op is accepted |

## Verification
The hardest case to reach is a stall that lands exactly on a group boundary or on the final micro-op while a second instruction is already waiting at the input. The bench gets there by driving consumer readiness from a free-running shift register. That sprinkles stalls at every position of every stream. On one third of the instructions it also holds a junk instruction valid on the input throughout the stream. A sweep over all 64 combinations of the six mode and count bits, each with three immediates, base and first-register values, covers the modulo-8 register wrap and both extreme displacements.

// File: rtl/fpmx_pkg.sv
package fpmx_pkg;
  localparam int unsigned INST_W       = 32;
  localparam int unsigned REG_W        = 3;
  localparam int unsigned RN_W         = 4;
  localparam int unsigned COND_W       = 4;
  localparam int unsigned IMM_W        = 8;
  localparam int unsigned DISP_SHIFT   = 2;
  localparam int unsigned DISP_W       = IMM_W + DISP_SHIFT;
  localparam int unsigned UOPS_PER_REG = 3;
  localparam int unsigned MAX_REGS     = 4;
  localparam int unsigned GRP_W        = $clog2(MAX_REGS);
  localparam int unsigned SLOT_W       = $clog2(UOPS_PER_REG);
  localparam int unsigned CNT_W        = $clog2(MAX_REGS + 1);

  // instruction field positions
  localparam int unsigned B_PRE   = 24;
  localparam int unsigned B_UP    = 23;
  localparam int unsigned B_CNTHI = 22;
  localparam int unsigned B_WB    = 21;
  localparam int unsigned B_LOAD  = 20;
  localparam int unsigned B_RN    = 16;
  localparam int unsigned B_CNTLO = 15;
  localparam int unsigned B_FIRST = 12;
  localparam int unsigned B_COND  = 28;

  localparam logic [INST_W-1:0] WB_OPC = 32'h0240_0000;

  typedef struct packed {
    logic [COND_W-1:0] cond;
    logic              pre;
    logic              up;
    logic              wb;
    logic              load;
    logic [RN_W-1:0]   rn;
    logic [REG_W-1:0]  first;
    logic [CNT_W-1:0]  count;
    logic [DISP_W-1:0] disp;
  } xfer_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WB   = 2'd2
  } st_e;
endpackage

// File: rtl/fpmx_decode.sv
module fpmx_decode
  import fpmx_pkg::*;
(
  input  logic [INST_W-1:0] inst_i,
  output xfer_t             fields_o
);
  logic [1:0] cnt_raw;

  assign cnt_raw = {inst_i[B_CNTHI], inst_i[B_CNTLO]};

  always_comb begin
    fields_o       = '0;
    fields_o.cond  = inst_i[B_COND +: COND_W];
    fields_o.pre   = inst_i[B_PRE];
    fields_o.up    = inst_i[B_UP];
    fields_o.wb    = inst_i[B_WB];
    fields_o.load  = inst_i[B_LOAD];
    fields_o.rn    = inst_i[B_RN +: RN_W];
    fields_o.first = inst_i[B_FIRST +: REG_W];
    // encoding zero selects the maximum count
    fields_o.count = (cnt_raw == 2'd0) ? CNT_W'(MAX_REGS) : CNT_W'(cnt_raw);
    fields_o.disp  = {inst_i[IMM_W-1:0], {DISP_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/fpmx_seq.sv
module fpmx_seq
  import fpmx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inst_valid_i,
  input  xfer_t             fields_i,
  input  logic              uop_ready_i,
  output logic              inst_ready_o,
  output st_e               st_o,
  output logic [GRP_W-1:0]  grp_o,
  output logic [SLOT_W-1:0] slot_o,
  output xfer_t             fields_o,
  output logic              last_o,
  output logic              done_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(UOPS_PER_REG - 1);

  st_e               st_q;
  logic [GRP_W-1:0]  grp_q;
  logic [SLOT_W-1:0] slot_q;
  xfer_t             f_q;
  logic              done_q;
  logic              grp_end;
  logic              xfer_end;

  assign grp_end  = (slot_q == LAST_SLOT);
  assign xfer_end = grp_end && (CNT_W'(grp_q) == f_q.count - CNT_W'(1));

  always_comb begin
    unique case (st_q)
      ST_XFER: last_o = xfer_end && !f_q.wb;
      ST_WB:   last_o = 1'b1;
      default: last_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      grp_q  <= '0;
      slot_q <= '0;
      f_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (inst_valid_i) begin
            f_q    <= fields_i;
            grp_q  <= '0;
            slot_q <= '0;
            st_q   <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (uop_ready_i) begin
            if (grp_end) begin
              slot_q <= '0;
              if (xfer_end) begin
                if (f_q.wb) begin
                  st_q <= ST_WB;
                end else begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                end
              end else begin
                grp_q <= grp_q + GRP_W'(1);
              end
            end else begin
              slot_q <= slot_q + SLOT_W'(1);
            end
          end
        end
        ST_WB: begin
          if (uop_ready_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign inst_ready_o = (st_q == ST_IDLE);
  assign st_o         = st_q;
  assign grp_o        = grp_q;
  assign slot_o       = slot_q;
  assign fields_o     = f_q;
  assign done_o       = done_q;
endmodule

// File: rtl/fpmx_uop_fmt.sv
module fpmx_uop_fmt
  import fpmx_pkg::*;
(
  input  st_e               st_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  xfer_t             fields_i,
  input  logic              last_i,
  output logic              valid_o,
  output logic              wb_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [REG_W-1:0]  reg_o,
  output logic [DISP_W-1:0] offset_o,
  output logic              load_o,
  output logic              up_o,
  output logic [INST_W-1:0] word_o,
  output logic              last_o
);
  logic [INST_W-1:0] wb_word;

  always_comb begin
    wb_word = WB_OPC;
    wb_word[B_COND +: COND_W] = fields_i.cond;
    wb_word = wb_word | (INST_W'(fields_i.rn) << 16) | (INST_W'(fields_i.rn) << 12)
                      | INST_W'(fields_i.disp);
  end

  always_comb begin
    valid_o  = (st_i != ST_IDLE);
    wb_o     = (st_i == ST_WB);
    load_o   = valid_o && fields_i.load;
    up_o     = valid_o && fields_i.up;
    last_o   = last_i;
    slot_o   = '0;
    reg_o    = '0;
    offset_o = '0;
    word_o   = '0;
    if (st_i == ST_XFER) begin
      slot_o   = slot_i;
      reg_o    = fields_i.first + REG_W'(grp_i);  // wraps modulo register file size
      offset_o = fields_i.pre ? fields_i.disp : '0;
    end else if (st_i == ST_WB) begin
      offset_o = fields_i.disp;
      word_o   = wb_word;
    end
  end
endmodule

// File: rtl/fpmx_cracker.sv
module fpmx_cracker
  import fpmx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inst_valid_i,
  output logic              inst_ready_o,
  input  logic [INST_W-1:0] inst_i,
  output logic              uop_valid_o,
  input  logic              uop_ready_i,
  output logic              uop_wb_o,
  output logic [SLOT_W-1:0] uop_slot_o,
  output logic [REG_W-1:0]  uop_reg_o,
  output logic [DISP_W-1:0] uop_offset_o,
  output logic              uop_load_o,
  output logic              uop_up_o,
  output logic [INST_W-1:0] uop_word_o,
  output logic              uop_last_o,
  output logic              done_o
);
  xfer_t             dec_fields;
  xfer_t             cur_fields;
  st_e               st;
  logic [GRP_W-1:0]  grp;
  logic [SLOT_W-1:0] slot;
  logic              last;

  fpmx_decode u_decode (
    .inst_i   (inst_i),
    .fields_o (dec_fields)
  );

  fpmx_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .inst_valid_i (inst_valid_i),
    .fields_i     (dec_fields),
    .uop_ready_i  (uop_ready_i),
    .inst_ready_o (inst_ready_o),
    .st_o         (st),
    .grp_o        (grp),
    .slot_o       (slot),
    .fields_o     (cur_fields),
    .last_o       (last),
    .done_o       (done_o)
  );

  fpmx_uop_fmt u_fmt (
    .st_i     (st),
    .grp_i    (grp),
    .slot_i   (slot),
    .fields_i (cur_fields),
    .last_i   (last),
    .valid_o  (uop_valid_o),
    .wb_o     (uop_wb_o),
    .slot_o   (uop_slot_o),
    .reg_o    (uop_reg_o),
    .offset_o (uop_offset_o),
    .load_o   (uop_load_o),
    .up_o     (uop_up_o),
    .word_o   (uop_word_o),
    .last_o   (uop_last_o)
  );
endmodule

// File: rtl/fpmx_cracker_chk.sv
module fpmx_cracker_chk
  import fpmx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inst_valid_i,
  input logic              inst_ready_o,
  input logic              uop_valid_o,
  input logic              uop_ready_i,
  input logic              uop_wb_o,
  input logic [SLOT_W-1:0] uop_slot_o,
  input logic [REG_W-1:0]  uop_reg_o,
  input logic [DISP_W-1:0] uop_offset_o,
  input logic              uop_load_o,
  input logic              uop_up_o,
  input logic [INST_W-1:0] uop_word_o,
  input logic              uop_last_o,
  input logic              done_o
);
  logic fire;
  assign fire = uop_valid_o && uop_ready_i;

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && !uop_ready_i) |=> (uop_valid_o && $stable(uop_wb_o) && $stable(uop_slot_o)
      && $stable(uop_reg_o) && $stable(uop_offset_o) && $stable(uop_word_o) && $stable(uop_last_o)));

  p_busy_not_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o |-> !inst_ready_o);

  p_done_after_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && uop_last_o) |=> (done_o && !uop_valid_o && inst_ready_o));

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_wb_is_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && uop_wb_o) |-> uop_last_o);

  p_last_xfer_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && !uop_wb_o && uop_last_o) |-> (uop_slot_o == SLOT_W'(UOPS_PER_REG - 1)));

  p_slot_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !uop_wb_o && (uop_slot_o == '0)) |=>
      (uop_valid_o && !uop_wb_o && (uop_slot_o == SLOT_W'(1)) && $stable(uop_reg_o)));

  p_wb_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && !uop_wb_o) |-> (uop_word_o == '0));
endmodule

bind fpmx_cracker fpmx_cracker_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .inst_valid_i (inst_valid_i),
  .inst_ready_o (inst_ready_o),
  .uop_valid_o  (uop_valid_o),
  .uop_ready_i  (uop_ready_i),
  .uop_wb_o     (uop_wb_o),
  .uop_slot_o   (uop_slot_o),
  .uop_reg_o    (uop_reg_o),
  .uop_offset_o (uop_offset_o),
  .uop_load_o   (uop_load_o),
  .uop_up_o     (uop_up_o),
  .uop_word_o   (uop_word_o),
  .uop_last_o   (uop_last_o),
  .done_o       (done_o)
);

// File: tb/fpmx_cracker_tb.sv
module fpmx_cracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inst_valid_i = 1'b0;
  logic        inst_ready_o;
  logic [31:0] inst_i = '0;
  logic        uop_valid_o;
  logic        uop_ready_i = 1'b0;
  logic        uop_wb_o;
  logic [1:0]  uop_slot_o;
  logic [2:0]  uop_reg_o;
  logic [9:0]  uop_offset_o;
  logic        uop_load_o;
  logic        uop_up_o;
  logic [31:0] uop_word_o;
  logic        uop_last_o;
  logic        done_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fpmx_cracker dut_i (
    .clk_i, .rst_ni, .inst_valid_i, .inst_ready_o, .inst_i,
    .uop_valid_o, .uop_ready_i, .uop_wb_o, .uop_slot_o, .uop_reg_o,
    .uop_offset_o, .uop_load_o, .uop_up_o, .uop_word_o, .uop_last_o, .done_o
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      bad = bad + 1;
      $display("FAIL watchdog: run hung actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic next_ready();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0] | lfsr[1];
  endfunction

  task automatic run_inst(input logic [31:0] w, input bit junk);
    int cnt, n, idx, guard;
    logic [9:0] disp;
    logic [31:0] exp_word;
    logic [2:0] exp_reg;
    logic [31:0] held;
    bit stalled;
    cnt  = {w[22], w[15]};
    if (cnt == 0) cnt = 4;
    n    = 3 * cnt + (w[21] ? 1 : 0);
    disp = {w[7:0], 2'b00};
    exp_word = {w[31:28], 28'h0} | 32'h0240_0000 | ({28'h0, w[19:16]} << 16)
             | ({28'h0, w[19:16]} << 12) | {22'h0, disp};
    @(negedge clk_i);
    inst_i = w;
    inst_valid_i = 1'b1;
    uop_ready_i = 1'b0;
    guard = 0;
    while (!inst_ready_o && guard < 100) begin @(negedge clk_i); guard++; end
    @(negedge clk_i);
    if (junk) inst_i = ~w ^ 32'h0000_8400; else inst_valid_i = 1'b0;
    idx = 0; stalled = 0; held = '0;
    guard = 0;
    while (idx < n && guard < 500) begin
      guard++;
      if (stalled)  // R8: outputs held across a stall
        chk("R8", "held", {uop_word_o[21:0], uop_offset_o} ^ {14'h0, uop_reg_o, uop_slot_o, uop_wb_o, uop_last_o, 12'h0},
            held);
      chk("R9", "valid/ready", {30'h0, uop_valid_o, inst_ready_o}, 32'h2);
      chk("R10", "done low mid-stream", {31'h0, done_o}, 32'h0);
      if (idx < 3 * cnt) begin
        exp_reg = w[14:12] + 3'(idx / 3);
        chk("R2", "wb flag", {31'h0, uop_wb_o}, 32'h0);
        chk("R3", "slot", {30'h0, uop_slot_o}, 32'(idx % 3));
        chk("R3", "reg", {29'h0, uop_reg_o}, {29'h0, exp_reg});
        chk("R4", "offset", {22'h0, uop_offset_o}, w[24] ? {22'h0, disp} : 32'h0);
        chk("R6", "xfer word zero", uop_word_o, 32'h0);
      end else begin
        chk("R5", "wb flag", {31'h0, uop_wb_o}, 32'h1);
        chk("R5", "wb offset", {22'h0, uop_offset_o}, {22'h0, disp});
        chk("R6", "wb word", uop_word_o, exp_word);
      end
      chk("R4", "load/up", {30'h0, uop_load_o, uop_up_o}, {30'h0, w[20], w[23]});
      chk("R7", "last", {31'h0, uop_last_o}, {31'h0, idx == n - 1});
      uop_ready_i = next_ready();
      if (junk && idx == n - 1) inst_valid_i = 1'b0;
      stalled = !uop_ready_i;
      held = {uop_word_o[21:0], uop_offset_o} ^ {14'h0, uop_reg_o, uop_slot_o, uop_wb_o, uop_last_o, 12'h0};
      if (uop_ready_i) idx++;
      @(negedge clk_i);
    end
    chk("R2", "micro-op total", 32'(idx), 32'(n));
    chk("R10", "done pulse", {29'h0, done_o, uop_valid_o, inst_ready_o}, 32'h5);
    uop_ready_i = 1'b0;
    @(negedge clk_i);
    chk("R10", "done single cycle", {31'h0, done_o}, 32'h0);
    chk("R9", "junk not taken", {30'h0, uop_valid_o, inst_ready_o}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "in reset", {29'h0, uop_valid_o, done_o, inst_ready_o}, 32'h1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "after reset", {29'h0, uop_valid_o, done_o, inst_ready_o}, 32'h1);
    for (int m = 0; m < 64; m++) begin
      for (int v = 0; v < 3; v++) begin
        logic [31:0] w;
        logic [7:0] imm;
        imm = (v == 0) ? 8'h00 : (v == 1) ? 8'hFF : 8'(8'h5A + m);
        w = '0;
        w[31:28] = 4'(m + 5 * v);
        w[27:25] = 3'b110;
        w[24] = m[5]; w[23] = m[4]; w[22] = m[3];
        w[21] = m[2]; w[20] = m[1]; w[15] = m[0];
        w[19:16] = 4'(m + v);
        w[14:12] = 3'(3 * m + v);
        w[11:8]  = 4'hC;
        w[7:0]   = imm;
        run_inst(w, v == 1);
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule